// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Status Flags

This block is a first-in, first-out buffer with a write port and a read port on two unrelated clocks. It drives a set of five status outputs: a primary empty-side flag, a primary full-side flag, a half-full flag, and two programmable threshold flags, one for almost-empty and one for almost-full. Write and read pointers cross between the clock domains as Gray code through two-flop synchronizers. The block silently discards a write into a full memory and a read from an empty memory.

When master reset is asserted, the block captures three settings. The first is the timing mode. In standard mode the primary flags mean empty and full, and the read port delivers a word one cycle after a read request. In fall-through mode the oldest word appears on the output by itself, the empty-side flag means output-ready, and the full-side flag means input-ready. The second setting chooses whether the two threshold flags update through registers in their own domain or follow both pointers directly. The third is a three-bit code that picks one of eight default threshold offsets. The write port can then load new offsets. Partial reset empties the buffer but keeps the captured mode, the flag timing choice and the offsets.

Top module: `dualclk_pflag_fifo`

## Requirements
- R1: In standard mode (mode_fall = 0 at master reset), stat_empty_ordy is 1 exactly when the memory holds no word, and stat_full_irdy is 1 exactly when it holds DEPTH words.
- R2: In fall-through mode (mode_fall = 1 at master reset), the oldest word is placed on dout without a read request and stat_empty_ordy rises with it. A read request while stat_empty_ordy is 1 replaces dout with the next word, or drops stat_empty_ordy if no word is left. stat_full_irdy is 1 while the memory holds fewer than DEPTH words. The word shown on dout is not counted in the memory, so the total capacity is DEPTH + 1.
- R3: A write while the memory holds DEPTH words is dropped. A read while the memory is empty (standard mode), or while stat_empty_ordy is 0 (fall-through mode), leaves dout and the pointers unchanged.
- R4: stat_half is 1 when the memory holds more than DEPTH/2 words.
- R5: stat_aempty is 1 when the memory count is at most the empty offset. stat_afull is 1 when DEPTH minus the count is at most the full offset.
- R6: During master reset, the code {ofs_load, ofs_sel[1], ofs_sel[0]} = k (0..7) sets both offsets to k + 1.
- R7: A write cycle with ofs_load = 1 stores din[AW-1:0] into the empty offset first and into the full offset next, alternating after that, and it writes nothing into the buffer.
- R8: Master reset empties the buffer and captures mode_fall and pflag_sync.
- R9: Partial reset empties the buffer and restarts the offset-load order at the empty offset. It keeps the timing mode, the flag timing choice and both offsets.
- R10: With pflag_sync = 0 at master reset, stat_aempty and stat_afull follow a write or a read on the very edge that performs it. With pflag_sync = 1, they are registered in the read and write domain respectively, and a write does not reach stat_aempty before read-clock edges carry it across.
- R11: Words leave the buffer in the order in which they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, active high, synchronous in each domain |
| prst | input | 1 | Partial reset, active high, synchronous in each domain |
| mode_fall | input | 1 | Fall-through mode select, captured during master reset |
| pflag_sync | input | 1 | Registered threshold flag timing select, captured during master reset |
| ofs_sel | input | 2 | Low bits of the default offset code |
| ofs_load | input | 1 | Top bit of the default code during master reset; offset load strobe afterwards |
| wen | input | 1 | Write request |
| din | input | DW | Write data, or offset value when loading |
| ren | input | 1 | Read request |
| dout | output | DW | Read data |
| stat_empty_ordy | output | 1 | Empty (standard) or output-ready (fall-through) |
| stat_full_irdy | output | 1 | Full (standard) or input-ready (fall-through) |
| stat_half | output | 1 | More than half full |
| stat_aempty | output | 1 | Almost empty |
| stat_afull | output | 1 | Almost full |

## Verification
The bound checker watches, on every edge, the rules that hold regardless of traffic. Neither domain's count ever exceeds DEPTH. A write refused because the memory is full does not move the write pointer, and in standard mode a read of an empty memory does not move the read pointer. In fall-through mode a presented word stays put until it is read. Partial reset zeroes the write pointer, and the captured mode never changes outside master reset. The bench's scenarios are needed to show flag values against a computed count at every fill level, the eight default offsets, the alternating offset load, data order, retention across partial reset, and the difference between direct and registered threshold timing seen just after an edge.

// File: rtl/pflag_fifo_pkg.sv
`timescale 1ns/1ps
package pflag_fifo_pkg;

    // Default threshold offset chosen by the three-bit code at master reset.
    function automatic logic [3:0] offset_from_code(input logic [2:0] code);
        return {1'b0, code} + 4'd1;
    endfunction

endpackage

// File: rtl/pflag_fifo_gsync.sv
`timescale 1ns/1ps
// Two-flop synchronizer for a Gray-coded pointer, converted back to binary.
module pflag_fifo_gsync #(
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] bin_out
);
    typedef struct packed {
        logic [PW-1:0] s1;
        logic [PW-1:0] s2;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d    = q;
        d.s1 = gray_in;
        d.s2 = q.s1;
        if (rst) d = '0;
    end

    always_ff @(posedge clk) q <= d;

    always_comb begin
        bin_out[PW-1] = q.s2[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            bin_out[i] = bin_out[i+1] ^ q.s2[i];
        end
    end
endmodule

// File: rtl/pflag_fifo_ram.sv
`timescale 1ns/1ps
// Storage array: registered write on wclk, combinational read.
module pflag_fifo_ram #(
    parameter int AW = 4,
    parameter int DW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/pflag_fifo_wr.sv
`timescale 1ns/1ps
// Write domain: pointer, offsets, full/half/almost-full flags.
module pflag_fifo_wr #(
    parameter int AW = 4,
    parameter int DW = 8,
    localparam int PW = AW + 1
) (
    input  logic          wclk,
    input  logic          mrst,
    input  logic          prst,
    input  logic          wen,
    input  logic          ofs_load,
    input  logic [DW-1:0] din,
    input  logic          mode_fall,
    input  logic          pflag_sync,
    input  logic [1:0]    ofs_sel,
    input  logic [PW-1:0] rbin_sync,
    input  logic [PW-1:0] rbin_live,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [PW-1:0] wbin,
    output logic [PW-1:0] wgray,
    output logic [AW-1:0] ofs_empty,
    output logic          full,
    output logic          stat_full_irdy,
    output logic          stat_half,
    output logic          stat_afull,
    output logic [PW-1:0] wcnt
);
    localparam logic [PW-1:0] FULL_CNT = {1'b1, {AW{1'b0}}};
    localparam logic [PW-1:0] HALF_CNT = {2'b01, {(AW-1){1'b0}}};

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic [AW-1:0] ofs_e;
        logic [AW-1:0] ofs_f;
        logic          pick_full;
        logic          fall;
        logic          sync;
        logic          afull_r;
    } wst_t;

    wst_t d, q;

    logic [AW-1:0] dflt;
    logic [PW-1:0] room;
    logic [PW-1:0] room_live;
    logic          wr_acc;

    assign dflt      = AW'(pflag_fifo_pkg::offset_from_code({ofs_load, ofs_sel}));
    assign wcnt      = q.bin - rbin_sync;
    assign full      = (wcnt == FULL_CNT);
    assign room      = FULL_CNT - wcnt;
    assign room_live = FULL_CNT - (q.bin - rbin_live);
    assign wr_acc    = wen && !ofs_load && !full;

    always_comb begin
        d = q;
        if (wr_acc) d.bin = q.bin + PW'(1);
        d.gray = d.bin ^ (d.bin >> 1);
        if (wen && ofs_load) begin
            if (q.pick_full) d.ofs_f = din[AW-1:0];
            else             d.ofs_e = din[AW-1:0];
            d.pick_full = !q.pick_full;
        end
        d.afull_r = (room <= {1'b0, q.ofs_f});
        if (mrst) begin
            d       = '0;
            d.fall  = mode_fall;
            d.sync  = pflag_sync;
            d.ofs_e = dflt;
            d.ofs_f = dflt;
        end else if (prst) begin
            d.bin       = '0;
            d.gray      = '0;
            d.pick_full = 1'b0;
            d.afull_r   = 1'b0;
        end
    end

    always_ff @(posedge wclk) q <= d;

    assign mem_we         = wr_acc && !mrst && !prst;
    assign mem_waddr      = q.bin[AW-1:0];
    assign wbin           = q.bin;
    assign wgray          = q.gray;
    assign ofs_empty      = q.ofs_e;
    assign stat_full_irdy = q.fall ? !full : full;
    assign stat_half      = (wcnt > HALF_CNT);
    assign stat_afull     = q.sync ? q.afull_r : (room_live <= {1'b0, q.ofs_f});
endmodule

// File: rtl/pflag_fifo_rd.sv
`timescale 1ns/1ps
// Read domain: pointer, output stage for both timing modes, empty/almost-empty.
module pflag_fifo_rd #(
    parameter int AW = 4,
    parameter int DW = 8,
    localparam int PW = AW + 1
) (
    input  logic          rclk,
    input  logic          mrst,
    input  logic          prst,
    input  logic          ren,
    input  logic          mode_fall,
    input  logic          pflag_sync,
    input  logic [PW-1:0] wbin_sync,
    input  logic [PW-1:0] wbin_live,
    input  logic [AW-1:0] ofs_empty,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_raddr,
    output logic [PW-1:0] rbin,
    output logic [PW-1:0] rgray,
    output logic [DW-1:0] dout,
    output logic          mem_empty,
    output logic          fall_mode,
    output logic          stat_empty_ordy,
    output logic          stat_aempty,
    output logic [PW-1:0] rcnt
);
    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic [DW-1:0] data;
        logic          held;
        logic          fall;
        logic          sync;
        logic          aempty_r;
    } rst_t;

    rst_t d, q;
    logic take;

    assign rcnt      = wbin_sync - q.bin;
    assign mem_empty = (rcnt == '0);
    assign take      = q.fall ? (!mem_empty && (!q.held || ren)) : (ren && !mem_empty);

    always_comb begin
        d = q;
        if (take) begin
            d.bin  = q.bin + PW'(1);
            d.data = mem_rdata;
        end
        if (q.fall) begin
            if (take)     d.held = 1'b1;
            else if (ren) d.held = 1'b0;
        end
        d.gray     = d.bin ^ (d.bin >> 1);
        d.aempty_r = (rcnt <= {1'b0, ofs_empty});
        if (mrst) begin
            d          = '0;
            d.fall     = mode_fall;
            d.sync     = pflag_sync;
            d.aempty_r = 1'b1;
        end else if (prst) begin
            d.bin      = '0;
            d.gray     = '0;
            d.held     = 1'b0;
            d.aempty_r = 1'b1;
        end
    end

    always_ff @(posedge rclk) q <= d;

    assign mem_raddr       = q.bin[AW-1:0];
    assign rbin            = q.bin;
    assign rgray           = q.gray;
    assign dout            = q.data;
    assign fall_mode       = q.fall;
    assign stat_empty_ordy = q.fall ? q.held : mem_empty;
    assign stat_aempty     = q.sync ? q.aempty_r : ((wbin_live - q.bin) <= {1'b0, ofs_empty});
endmodule

// File: rtl/dualclk_pflag_fifo.sv
`timescale 1ns/1ps
module dualclk_pflag_fifo #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          mrst,
    input  logic          prst,
    input  logic          mode_fall,
    input  logic          pflag_sync,
    input  logic [1:0]    ofs_sel,
    input  logic          ofs_load,
    input  logic          wen,
    input  logic [DW-1:0] din,
    input  logic          ren,
    output logic [DW-1:0] dout,
    output logic          stat_empty_ordy,
    output logic          stat_full_irdy,
    output logic          stat_half,
    output logic          stat_aempty,
    output logic          stat_afull
);
    localparam int PW = AW + 1;

    logic          mem_we;
    logic [AW-1:0] mem_waddr, mem_raddr, ofs_empty;
    logic [DW-1:0] mem_rdata;
    logic [PW-1:0] w_bin, w_gray, r_bin, r_gray, w_bin_s, r_bin_s, w_cnt, r_cnt;
    logic          w_full, r_empty, r_fall;
    logic          w_rst, r_rst;

    assign w_rst = mrst || prst;
    assign r_rst = mrst || prst;

    pflag_fifo_ram #(.AW(AW), .DW(DW)) ram_i (
        .wclk(wclk), .we(mem_we), .waddr(mem_waddr), .wdata(din),
        .raddr(mem_raddr), .rdata(mem_rdata)
    );

    pflag_fifo_gsync #(.PW(PW)) r2w_i (
        .clk(wclk), .rst(w_rst), .gray_in(r_gray), .bin_out(r_bin_s)
    );

    pflag_fifo_gsync #(.PW(PW)) w2r_i (
        .clk(rclk), .rst(r_rst), .gray_in(w_gray), .bin_out(w_bin_s)
    );

    pflag_fifo_wr #(.AW(AW), .DW(DW)) wr_i (
        .wclk(wclk), .mrst(mrst), .prst(prst), .wen(wen), .ofs_load(ofs_load),
        .din(din), .mode_fall(mode_fall), .pflag_sync(pflag_sync), .ofs_sel(ofs_sel),
        .rbin_sync(r_bin_s), .rbin_live(r_bin), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .wbin(w_bin), .wgray(w_gray), .ofs_empty(ofs_empty), .full(w_full),
        .stat_full_irdy(stat_full_irdy), .stat_half(stat_half), .stat_afull(stat_afull),
        .wcnt(w_cnt)
    );

    pflag_fifo_rd #(.AW(AW), .DW(DW)) rd_i (
        .rclk(rclk), .mrst(mrst), .prst(prst), .ren(ren), .mode_fall(mode_fall),
        .pflag_sync(pflag_sync), .wbin_sync(w_bin_s), .wbin_live(w_bin),
        .ofs_empty(ofs_empty), .mem_rdata(mem_rdata), .mem_raddr(mem_raddr),
        .rbin(r_bin), .rgray(r_gray), .dout(dout), .mem_empty(r_empty),
        .fall_mode(r_fall), .stat_empty_ordy(stat_empty_ordy),
        .stat_aempty(stat_aempty), .rcnt(r_cnt)
    );
endmodule

// File: rtl/pflag_fifo_chk.sv
`timescale 1ns/1ps
module pflag_fifo_chk #(
    parameter int AW = 4,
    parameter int DW = 8,
    localparam int PW = AW + 1
) (
    input logic          wclk,
    input logic          rclk,
    input logic          mrst,
    input logic          prst,
    input logic          wen,
    input logic          ofs_load,
    input logic          ren,
    input logic [DW-1:0] dout,
    input logic          stat_empty_ordy,
    input logic [PW-1:0] w_cnt,
    input logic [PW-1:0] r_cnt,
    input logic [PW-1:0] w_bin,
    input logic [PW-1:0] r_bin,
    input logic          w_full,
    input logic          r_empty,
    input logic          r_fall
);
    localparam logic [PW-1:0] FULL_CNT = {1'b1, {AW{1'b0}}};

    AST_WCNT_BOUND: assert property (@(posedge wclk) disable iff (mrst || prst)
        w_cnt <= FULL_CNT); // R3
    AST_RCNT_BOUND: assert property (@(posedge rclk) disable iff (mrst || prst)
        r_cnt <= FULL_CNT); // R3
    AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (mrst || prst)
        (w_full && wen && !ofs_load) |=> $stable(w_bin)); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (mrst || prst)
        (!r_fall && r_empty && ren) |=> $stable(r_bin)); // R3
    AST_FALL_HOLD: assert property (@(posedge rclk) disable iff (mrst || prst)
        (r_fall && stat_empty_ordy && !ren) |=> (stat_empty_ordy && $stable(dout))); // R2
    AST_PRST_CLEARS: assert property (@(posedge wclk) disable iff (mrst)
        prst |=> (w_bin == '0)); // R9
    AST_MODE_KEPT: assert property (@(posedge rclk) disable iff (mrst)
        !mrst |=> $stable(r_fall)); // R9
endmodule

bind dualclk_pflag_fifo pflag_fifo_chk #(.AW(AW), .DW(DW)) chk_i (
    .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst), .wen(wen),
    .ofs_load(ofs_load), .ren(ren), .dout(dout), .stat_empty_ordy(stat_empty_ordy),
    .w_cnt(w_cnt), .r_cnt(r_cnt), .w_bin(w_bin), .r_bin(r_bin),
    .w_full(w_full), .r_empty(r_empty), .r_fall(r_fall)
);

// File: tb/dualclk_pflag_fifo_tb_top.sv
`timescale 1ns/100ps
module dualclk_pflag_fifo_tb_top;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    logic wclk = 1'b0, rclk = 1'b0;
    logic mrst = 1'b1, prst = 1'b0, mode_fall = 1'b0, pflag_sync = 1'b1;
    logic [1:0] ofs_sel = 2'b00;
    logic ofs_load = 1'b0, wen = 1'b0, ren = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic stat_empty_ordy, stat_full_irdy, stat_half, stat_aempty, stat_afull;

    int checks = 0, failures = 0;

    // Reference model
    logic [DW-1:0] model_q[$];
    bit fall_m = 1'b0;
    int oe_m = 1, of_m = 1;
    bit pick_m = 1'b0;

    dualclk_pflag_fifo #(.AW(AW), .DW(DW)) dut_i (
        .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst), .mode_fall(mode_fall),
        .pflag_sync(pflag_sync), .ofs_sel(ofs_sel), .ofs_load(ofs_load), .wen(wen),
        .din(din), .ren(ren), .dout(dout), .stat_empty_ordy(stat_empty_ordy),
        .stat_full_irdy(stat_full_irdy), .stat_half(stat_half),
        .stat_aempty(stat_aempty), .stat_afull(stat_afull)
    );

    always #2.5 wclk = ~wclk;
    initial begin
        #1.25;
        forever #2.5 rclk = ~rclk;
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        summary();
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string ctx, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s (%s): actual=%0d expected=%0d", req, ctx, act, exp);
        end
    endtask

    function automatic int memc();
        int h = model_q.size();
        if (fall_m) return (h > 0) ? h - 1 : 0;
        return h;
    endfunction

    task automatic settle();
        repeat (8) @(posedge wclk);
        #0.5;
    endtask

    task automatic check_state(input string ctx);
        int m = memc();
        int ea, eb;
        ea = fall_m ? int'(model_q.size() > 0) : int'(m == 0);
        eb = fall_m ? int'(m < DEPTH) : int'(m == DEPTH);
        chk(stat_empty_ordy === ea[0], fall_m ? "R2" : "R1", {ctx, " empty/ready"}, int'(stat_empty_ordy), ea);
        chk(stat_full_irdy === eb[0], fall_m ? "R2" : "R1", {ctx, " full/ready"}, int'(stat_full_irdy), eb);
        chk(stat_half === (m > DEPTH / 2), "R4", ctx, int'(stat_half), int'(m > DEPTH / 2));
        chk(stat_aempty === (m <= oe_m), "R5", {ctx, " aempty"}, int'(stat_aempty), int'(m <= oe_m));
        chk(stat_afull === ((DEPTH - m) <= of_m), "R5", {ctx, " afull"}, int'(stat_afull), int'((DEPTH - m) <= of_m));
        if (fall_m && model_q.size() > 0)
            chk(dout === model_q[0], "R2", {ctx, " presented word"}, int'(dout), int'(model_q[0]));
    endtask

    task automatic mreset(input bit f, input bit s, input logic [2:0] code);
        mode_fall = f; pflag_sync = s; ofs_sel = code[1:0]; ofs_load = code[2];
        wen = 1'b0; ren = 1'b0; mrst = 1'b1;
        repeat (4) @(posedge wclk);
        #1; mrst = 1'b0; ofs_load = 1'b0;
        model_q.delete();
        fall_m = f; oe_m = int'(code) + 1; of_m = int'(code) + 1; pick_m = 1'b0;
        settle();
    endtask

    task automatic preset();
        prst = 1'b1;
        repeat (3) @(posedge wclk);
        #1; prst = 1'b0;
        model_q.delete();
        pick_m = 1'b0;
        settle();
    endtask

    task automatic wr(input logic [DW-1:0] v);
        @(posedge wclk); #1; wen = 1'b1; din = v;
        @(posedge wclk); #0.5; wen = 1'b0;
        if (memc() < DEPTH) model_q.push_back(v);
    endtask

    task automatic load_ofs(input int v);
        @(posedge wclk); #1; wen = 1'b1; ofs_load = 1'b1; din = DW'(v);
        @(posedge wclk); #0.5; wen = 1'b0; ofs_load = 1'b0;
        if (pick_m) of_m = v; else oe_m = v;
        pick_m = !pick_m;
    endtask

    task automatic rd(input string ctx);
        logic [DW-1:0] old, exp;
        old = dout;
        @(posedge rclk); #1; ren = 1'b1;
        @(posedge rclk); #0.5; ren = 1'b0;
        if (!fall_m) begin
            if (model_q.size() > 0) begin
                exp = model_q.pop_front();
                chk(dout === exp, "R11", ctx, int'(dout), int'(exp));
            end else begin
                chk(dout === old, "R3", {ctx, " read of empty"}, int'(dout), int'(old));
            end
        end else if (model_q.size() > 0) begin
            void'(model_q.pop_front());
        end
    endtask

    initial begin
        // Standard mode, registered threshold flags, default code 0
        mreset(1'b0, 1'b1, 3'd0);
        check_state("R8 reset state standard");
        for (int i = 0; i < DEPTH; i++) begin
            wr(DW'(8'hA0 + i)); settle(); check_state("R1 fill sweep");
        end
        wr(8'hEE); settle(); check_state("R3 write when full");
        for (int i = 0; i < DEPTH; i++) begin
            rd("R11 drain order"); settle(); check_state("R1 drain sweep");
        end
        rd("R3 empty read"); settle(); check_state("R3 after empty read");
        wr(8'h5A); settle(); rd("R3 pointer unmoved"); settle(); check_state("R1 after refill");

        // Offset programming and partial reset
        load_ofs(3); load_ofs(5); settle();
        chk(stat_empty_ordy === 1'b1, "R7", "load writes no word", int'(stat_empty_ordy), 1);
        check_state("R7 after load");
        for (int i = 0; i < 10; i++) begin
            wr(DW'(8'h10 + i)); settle(); check_state("R7 programmed thresholds");
        end
        preset();
        check_state("R9 after partial reset");
        for (int i = 0; i < 5; i++) begin
            wr(DW'(8'h30 + i)); settle(); check_state("R9 offsets kept");
        end
        rd("R9 data after partial reset");

        // Fall-through mode
        mreset(1'b1, 1'b1, 3'd0);
        check_state("R8 reset state fall-through");
        for (int i = 0; i <= DEPTH; i++) begin
            wr(DW'(8'h40 + i)); settle(); check_state("R2 fill sweep");
        end
        wr(8'hEE); settle(); check_state("R3 write when no room");
        for (int i = 0; i <= DEPTH; i++) begin
            rd("R2 advance"); settle(); check_state("R2 drain sweep");
        end
        rd("R3 read when not ready"); settle(); check_state("R3 after ignored read");
        wr(8'h61); wr(8'h62); wr(8'h63); settle();
        preset();
        check_state("R9 fall-through partial reset");
        wr(8'h77); settle(); check_state("R9 mode kept");

        // Default offset codes
        for (int k = 0; k < 8; k++) begin
            mreset(1'b0, 1'b1, 3'(k));
            for (int n = 0; n < k + 3; n++) begin
                wr(DW'(n)); settle(); check_state("R6 default offset");
            end
        end

        // Direct (unregistered) threshold flags
        mreset(1'b0, 1'b0, 3'd0);
        wr(8'h01); wr(8'h02);
        chk(stat_aempty === 1'b0, "R10", "direct aempty on write edge", int'(stat_aempty), 0);
        settle();
        for (int i = 0; i < DEPTH - 2; i++) begin
            wr(DW'(8'h03 + i)); settle();
        end
        check_state("R10 direct full");
        rd("R10 read 1"); rd("R10 read 2");
        chk(stat_afull === 1'b0, "R10", "direct afull on read edge", int'(stat_afull), 0);
        settle(); check_state("R10 direct settled");

        // Registered threshold flags lag
        mreset(1'b0, 1'b1, 3'd0);
        wr(8'h01); wr(8'h02);
        chk(stat_aempty === 1'b1, "R10", "registered aempty lags write", int'(stat_aempty), 1);
        settle();
        for (int i = 0; i < DEPTH - 2; i++) begin
            wr(DW'(8'h03 + i)); settle();
        end
        rd("R10 read 1"); rd("R10 read 2");
        chk(stat_afull === 1'b1, "R10", "registered afull lags read", int'(stat_afull), 1);
        settle(); check_state("R10 registered settled");

        summary();
        $finish;
    end
endmodule